// File: doc/BRIEF.md
# Command Ring Pointer Controller

This block steers instruction fetch from a circular command buffer in memory. Software sets the buffer's base, its length and an enable bit, and moves a producer pointer (tail) over a narrow write-only register bus. The block keeps the consumer pointer (head) and requests one command dword at a time, from the head position, for as long as the head has not caught up with the tail. Each command word that comes back moves the head on by one dword. The head folds back to zero at the programmed length.

Two opcodes in the returned words are recognised. One is an arbitration checkpoint: if software has placed a redirect offset in the pending-head register, the head jumps to that offset and the redirect is used up. The other is a head report: the updated head offset is posted to a fixed dword slot of a status page, so the driver can poll memory rather than a register. A request to change context is held until the ring has drained. The switch is then announced with a single pulse.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: After synchronous reset the head, tail and base are zero and fetching is disabled. `fetch_req`, `stat_we` and `switch_go` are low and `idle` is high.
- R2: A write to the base register (`wr_sel`=2) clears the low 12 bits of the data, so the base always sits on a 4 KB boundary. `fetch_addr` equals base plus four times the head dword index.
- R3: `idle` is high exactly when the head equals the tail. `fetch_req` is high exactly when the ring is enabled and not idle. The control register (`wr_sel`=3) carries the enable in bit 0.
- R4: Each `rd_valid` cycle in which `fetch_req` is high moves the head forward by one dword. `rd_valid` while `fetch_req` is low changes nothing.
- R5: The ring length in dwords is (field+1)*1024, where field is control bits [PAGE_W+11:12]. The default PAGE_W gives a 2 MB ceiling. The head goes from length-1 to zero.
- R6: A write to the pending register (`wr_sel`=4, byte offset) arms a redirect. A consumed word with opcode 9'h005 in bits [31:23] (`rd_opcode`) then loads the head with that offset and disarms the redirect.
- R7: The opcode 9'h005 with no redirect armed moves the head forward like any other word.
- R8: One cycle after a word with opcode 9'h007 is consumed, `stat_we` pulses for one cycle. `stat_addr` is dword slot 4 and `stat_data` holds the byte offset of the updated head.
- R9: Writing the context register (`wr_sel`=5, bits [7:0]) with a value that differs from the current one requests a switch. `switch_go` pulses for one cycle, one cycle after the first cycle in which the request is pending and the ring is idle. Writing the current value requests nothing.
- R10: Tail (`wr_sel`=0) and head (`wr_sel`=1) writes take a byte offset, and bits [1:0] are dropped. A head write wins over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 tail, 1 head, 2 base, 3 control, 4 pending, 5 context) |
| wr_data | input | ADDR_W | Register write data |
| fetch_req | output | 1 | A command dword is wanted |
| fetch_addr | output | ADDR_W | Byte address of the wanted dword |
| rd_valid | input | 1 | The wanted dword has been returned |
| rd_opcode | input | 9 | Opcode field, bits [31:23], of the returned dword |
| idle | output | 1 | Head equals tail |
| stat_we | output | 1 | Status-page write strobe |
| stat_addr | output | STAT_AW | Status-page dword slot |
| stat_data | output | ADDR_W | Reported head byte offset |
| switch_go | output | 1 | Context switch may proceed |

## Verification
The bench builds the block with PAGE_W=3, which caps the ring at 8192 dwords. This makes both the smallest and the largest programmable length cheap to exercise. Head writes place the pointer a dword or two short of either limit, so the fold back to zero is reached in a couple of fetches. Every other parameter keeps its default.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  typedef enum logic [2:0] {
    SEL_TAIL  = 3'd0,
    SEL_HEAD  = 3'd1,
    SEL_START = 3'd2,
    SEL_CTL   = 3'd3,
    SEL_PEND  = 3'd4,
    SEL_CTX   = 3'd5
  } reg_sel_e;

  localparam int          OPC_W           = 9;
  localparam logic [8:0]  OPC_ARB_CHECK   = 9'h005;
  localparam logic [8:0]  OPC_REPORT_HEAD = 9'h007;
  localparam int          STAT_SLOT       = 4;
  localparam int          PAGE_SHIFT      = 12;
  localparam int          DW_PAGE_LOG2    = 10;
endpackage

// File: rtl/rp_regs.sv
module rp_regs
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 9,
  parameter int CTX_W  = 8,
  localparam int HW    = PAGE_W + DW_PAGE_LOG2,
  localparam int LW    = HW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              pend_take,
  output logic [HW-1:0]     tail_q,
  output logic [ADDR_W-1:0] start_q,
  output logic              enable_q,
  output logic [LW-1:0]     len_q,
  output logic [HW-1:0]     pend_q,
  output logic              pend_vld_q,
  output logic              ctx_arm
);
  logic [CTX_W-1:0] ctx_q;
  logic [PAGE_W:0]  pages;

  assign pages   = {1'b0, wr_data[PAGE_W+PAGE_SHIFT-1:PAGE_SHIFT]} + {{PAGE_W{1'b0}}, 1'b1};
  assign ctx_arm = wr_en && (reg_sel_e'(wr_sel) == SEL_CTX) && (wr_data[CTX_W-1:0] != ctx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q     <= '0;
      start_q    <= '0;
      enable_q   <= 1'b0;
      len_q      <= LW'(1) << DW_PAGE_LOG2;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      ctx_q      <= '0;
    end else begin
      if (pend_take) pend_vld_q <= 1'b0;
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_TAIL:  tail_q  <= wr_data[HW+1:2];
          SEL_START: start_q <= {wr_data[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
          SEL_CTL: begin
            enable_q <= wr_data[0];
            len_q    <= {pages, {DW_PAGE_LOG2{1'b0}}};
          end
          SEL_PEND: begin
            pend_q     <= wr_data[HW+1:2];
            pend_vld_q <= 1'b1;
          end
          SEL_CTX:   ctx_q <= wr_data[CTX_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rp_head.sv
module rp_head
  import ring_ptr_pkg::*;
#(
  parameter int PAGE_W = 9,
  localparam int HW    = PAGE_W + DW_PAGE_LOG2,
  localparam int LW    = HW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_wr,
  input  logic [HW-1:0]    head_wdata,
  input  logic             take,
  input  logic [OPC_W-1:0] opcode,
  input  logic [LW-1:0]    len_q,
  input  logic [HW-1:0]    pend_q,
  input  logic             pend_vld,
  output logic [HW-1:0]    head_q,
  output logic [HW-1:0]    head_nxt,
  output logic             pend_take,
  output logic             report_req
);
  logic [LW-1:0] head_inc;
  logic [HW-1:0] head_step;

  always_comb begin
    head_inc   = {1'b0, head_q} + LW'(1);
    head_step  = (head_inc == len_q) ? '0 : head_inc[HW-1:0];
    pend_take  = take && (opcode == OPC_ARB_CHECK) && pend_vld;
    report_req = take && (opcode == OPC_REPORT_HEAD);
    head_nxt   = pend_take ? pend_q : head_step;
  end

  always_ff @(posedge clk) begin
    if (rst)          head_q <= '0;
    else if (head_wr) head_q <= head_wdata;
    else if (take)    head_q <= head_nxt;
  end
endmodule

// File: rtl/rp_report.sv
module rp_report
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 9,
  localparam int HW    = PAGE_W + DW_PAGE_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              report_req,
  input  logic [HW-1:0]     report_head,
  input  logic              ctx_arm,
  input  logic              idle,
  output logic              stat_we,
  output logic [ADDR_W-1:0] stat_data,
  output logic              switch_go
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_we   <= 1'b0;
      stat_data <= '0;
      switch_go <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      stat_we <= report_req;
      if (report_req) stat_data <= ADDR_W'({report_head, 2'b00});
      switch_go <= armed_q && idle;
      if (ctx_arm)              armed_q <= 1'b1;
      else if (armed_q && idle) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 9,
  parameter int CTX_W   = 8,
  parameter int STAT_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic               fetch_req,
  output logic [ADDR_W-1:0]  fetch_addr,
  input  logic               rd_valid,
  input  logic [8:0]         rd_opcode,
  output logic               idle,
  output logic               stat_we,
  output logic [STAT_AW-1:0] stat_addr,
  output logic [ADDR_W-1:0]  stat_data,
  output logic               switch_go
);
  localparam int HW = PAGE_W + DW_PAGE_LOG2;
  localparam int LW = HW + 1;

  logic [HW-1:0]     tail_q, head_q, head_nxt, pend_q;
  logic [ADDR_W-1:0] start_q;
  logic [LW-1:0]     len_q;
  logic              enable_q, pend_vld_q, pend_take, report_req, ctx_arm;
  logic              take, head_wr;

  assign head_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_HEAD);
  assign idle       = (head_q == tail_q);
  assign fetch_req  = enable_q && !idle;
  assign take       = rd_valid && fetch_req;
  assign fetch_addr = start_q + ADDR_W'({head_q, 2'b00});
  assign stat_addr  = STAT_AW'(STAT_SLOT);

  rp_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CTX_W(CTX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pend_take(pend_take), .tail_q(tail_q), .start_q(start_q),
    .enable_q(enable_q), .len_q(len_q), .pend_q(pend_q),
    .pend_vld_q(pend_vld_q), .ctx_arm(ctx_arm)
  );

  rp_head #(.PAGE_W(PAGE_W)) u_head (
    .clk(clk), .rst(rst), .head_wr(head_wr), .head_wdata(wr_data[HW+1:2]),
    .take(take), .opcode(rd_opcode), .len_q(len_q), .pend_q(pend_q),
    .pend_vld(pend_vld_q), .head_q(head_q), .head_nxt(head_nxt),
    .pend_take(pend_take), .report_req(report_req)
  );

  rp_report #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_report (
    .clk(clk), .rst(rst), .report_req(report_req), .report_head(head_nxt),
    .ctx_arm(ctx_arm), .idle(idle), .stat_we(stat_we),
    .stat_data(stat_data), .switch_go(switch_go)
  );
endmodule

// File: rtl/ring_ptr_ctrl_chk.sv
module ring_ptr_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              rd_valid,
  input logic              idle,
  input logic              stat_we,
  input logic              switch_go
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fetch_req && idle && !stat_we && !switch_go));

  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !rd_valid && !wr_en) |=> fetch_req);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!fetch_req && !wr_en) |=> $stable(fetch_addr));

  assert_report_cause_R8: assert property (@(posedge clk) disable iff (rst)
    stat_we |-> $past(rd_valid && fetch_req));

  assert_go_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    switch_go |=> !switch_go);

  assert_go_idle_R9: assert property (@(posedge clk) disable iff (rst)
    switch_go |-> $past(idle));
endmodule

bind ring_ptr_ctrl ring_ptr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .fetch_req(fetch_req),
  .fetch_addr(fetch_addr), .rd_valid(rd_valid), .idle(idle),
  .stat_we(stat_we), .switch_go(switch_go)
);

// File: tb/tb_ring_ptr_ctrl.sv
module tb_ring_ptr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 3;
  localparam int HMASK = (1 << (PW + 10)) - 1;
  localparam int PMASK = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          rd_valid = 1'b0;
  logic [8:0]    rd_opcode = '0;
  logic          fetch_req, idle, stat_we, switch_go;
  logic [AW-1:0] fetch_addr, stat_data;
  logic [9:0]    stat_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  ring_ptr_ctrl #(.ADDR_W(AW), .PAGE_W(PW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .rd_valid(rd_valid),
    .rd_opcode(rd_opcode), .idle(idle), .stat_we(stat_we),
    .stat_addr(stat_addr), .stat_data(stat_data), .switch_go(switch_go)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  int m_head, m_tail, m_start, m_len, m_pend, m_ctx, m_stat_data, nh;
  bit m_en, m_pv, m_arm, m_stat_we, m_go, fr, go_n;

  always @(posedge clk) begin
    if (rst) begin
      m_head = 0; m_tail = 0; m_start = 0; m_len = 1024; m_pend = 0;
      m_ctx = 0; m_stat_data = 0; m_en = 0; m_pv = 0; m_arm = 0;
      m_stat_we = 0; m_go = 0;
    end else begin
      fr = m_en && (m_head != m_tail);
      go_n = m_arm && (m_head == m_tail);
      if (go_n) m_arm = 0;
      m_stat_we = 0;
      if (rd_valid && fr) begin
        nh = (m_head + 1 == m_len) ? 0 : m_head + 1;
        if (rd_opcode == 9'h005 && m_pv) begin nh = m_pend; m_pv = 0; end
        if (rd_opcode == 9'h007) begin m_stat_we = 1; m_stat_data = nh * 4; end
        m_head = nh;
      end
      m_go = go_n;
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_tail = (int'(wr_data) >> 2) & HMASK;
          3'd1: m_head = (int'(wr_data) >> 2) & HMASK;
          3'd2: m_start = int'(wr_data & 32'hFFFF_F000);
          3'd3: begin
            m_en = wr_data[0];
            m_len = (((int'(wr_data) >> 12) & PMASK) + 1) * 1024;
          end
          3'd4: begin m_pend = (int'(wr_data) >> 2) & HMASK; m_pv = 1; end
          3'd5: begin
            if (int'(wr_data[7:0]) != m_ctx) m_arm = 1;
            m_ctx = int'(wr_data[7:0]);
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 fetch_req", fetch_req, m_en && (m_head != m_tail));
      chk("R3 idle", idle, m_head == m_tail);
      chk("R4 fetch_addr", fetch_addr, (m_start + m_head * 4) & 32'hFFFF_FFFF);
      chk("R8 stat_we", stat_we, m_stat_we);
      if (m_stat_we) begin
        chk("R8 stat_data", stat_data, m_stat_data);
        chk("R8 stat_addr", stat_addr, 4);
      end
      chk("R9 switch_go", switch_go, m_go);
    end
  end

  task automatic wreg(input logic [2:0] sel, input logic [AW-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic feed(input logic [8:0] opc);
    rd_valid = 1'b1; rd_opcode = opc;
    @(negedge clk);
    rd_valid = 1'b0; rd_opcode = '0;
  endtask

  task automatic wrap_up;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 fetch_req", fetch_req, 0);
    chk("R1 idle", idle, 1);
    chk("R1 stat_we", stat_we, 0);
    chk("R1 switch_go", switch_go, 0);
    chk("R1 fetch_addr", fetch_addr, 0);

    // R2 base alignment, R3 enable
    wreg(3'd2, 32'h0001_2345);
    wreg(3'd0, 32'h0000_0010);
    chk("R3 disabled no fetch", fetch_req, 0);
    chk("R3 not idle", idle, 0);
    wreg(3'd3, 32'h0000_0001);
    chk("R2 aligned base", fetch_addr, 32'h0001_2000);
    chk("R3 fetch on", fetch_req, 1);

    // R4 advance to tail
    for (int i = 0; i < 4; i++) feed(9'h000);
    chk("R4 head at tail", fetch_addr, 32'h0001_2010);
    chk("R3 idle after drain", idle, 1);
    feed(9'h000);
    chk("R4 ignored when idle", fetch_addr, 32'h0001_2010);

    // R5 wrap at minimum length, R10 low bits dropped
    wreg(3'd1, 32'h0000_0FFB);
    wreg(3'd0, 32'h0000_0008);
    chk("R10 head low bits", fetch_addr, 32'h0001_2FF8);
    feed(9'h000); feed(9'h000);
    chk("R5 wrap 1024", fetch_addr, 32'h0001_2000);
    feed(9'h000);
    chk("R5 after wrap", fetch_addr, 32'h0001_2004);

    // R5 maximum length
    wreg(3'd3, 32'h0000_7001);
    wreg(3'd1, 32'h0000_7FF8);
    wreg(3'd0, 32'h0000_0004);
    feed(9'h000);
    chk("R5 no early wrap", fetch_addr, 32'h0001_9FFC);
    feed(9'h000);
    chk("R5 wrap max", fetch_addr, 32'h0001_2000);

    // R6 redirect, R7 checkpoint without redirect
    wreg(3'd0, 32'h0000_0400);
    wreg(3'd4, 32'h0000_0100);
    feed(9'h000);
    chk("R6 not taken by plain word", fetch_addr, 32'h0001_2004);
    feed(9'h005);
    chk("R6 redirect", fetch_addr, 32'h0001_2100);
    feed(9'h005);
    chk("R7 plain advance", fetch_addr, 32'h0001_2104);

    // R8 head report
    feed(9'h007);
    chk("R8 pulse", stat_we, 1);
    chk("R8 data", stat_data, 32'h0000_0108);
    chk("R8 slot", stat_addr, 4);
    @(negedge clk);
    chk("R8 single", stat_we, 0);

    // R9 context switch waits for idle
    wreg(3'd5, 32'h0000_0003);
    @(negedge clk);
    chk("R9 held while busy", switch_go, 0);
    wreg(3'd0, 32'h0000_0108);
    @(negedge clk);
    chk("R9 go when idle", switch_go, 1);
    @(negedge clk);
    chk("R9 one pulse", switch_go, 0);
    wreg(3'd5, 32'h0000_0003);
    @(negedge clk);
    chk("R9 same id no go", switch_go, 0);

    // R10 head write beats advance
    wreg(3'd0, 32'h0000_0400);
    rd_valid = 1'b1; rd_opcode = 9'h000;
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0000_0040;
    @(negedge clk);
    rd_valid = 1'b0; wr_en = 1'b0;
    chk("R10 write wins", fetch_addr, 32'h0001_2040);

    repeat (3) @(negedge clk);
    wrap_up();
  end
endmodule